// File: doc/BRIEF.md
# Edge-Interval Capture Timer

This block is one timer channel that measures the time between rising edges on an asynchronous input. A free-running up-counter restarts from zero on every accepted edge. The value it held at that moment goes into a capture register, and a one-cycle interrupt pulse is raised. A start pulse arms the counter and restarts it from zero.

A single overflow status bit reports whether the measured interval was longer than the counter range. The bit is deferred. A counter wrap only marks an internal pending latch. The status bit takes the latch value at the next capture, so it describes the interval that capture closes.

A three-bit mode input selects the behaviour:
- **Continuous capture** (`3'b010`): the counter keeps running after each capture.
- **Single-shot capture** (`3'b110`): the counter halts after one capture until the next start pulse.
- **Any other code**: the channel is idle and its state is frozen.

A small read port returns either the 16-bit status word or the capture value.

Top module: `cap_interval_timer`

## Requirements
- R1: While armed in a capture mode, the counter rises by one per clock from 0. A capture stores the count held just before the capture edge and restarts the counter at 0. The first capture after a start at clock edge S, taken at edge C, stores (C-S-1) modulo 2^CNT_W.
- R2: The input goes through two synchronizer flops, and only a rising edge of the synchronized level is accepted. An input that rises just after edge X is captured at edge X+3. `cap_irq` is high for exactly the one cycle after that edge. Holding the input high causes no further capture.
- R3: A counter wrap leaves the status bit unchanged until the next capture.
- R4: At a capture, the status bit becomes 1 if the counter wrapped at least once since the previous capture or start.
- R5: At a capture, the status bit becomes 0 if no wrap occurred since the previous capture or start, even when it was 1.
- R6: A wrap on the same clock as a capture belongs to the interval being closed. With CNT_W=8, an elapsed interval of 256 clocks stores 255 with status 1, 255 clocks stores 254 with status 0, and 257 clocks stores 0 with status 1.
- R7: In mode `3'b110`, the counter stops after a capture. Further edges cause no capture and no interrupt until a new start pulse.
- R8: For any mode code other than `3'b010` or `3'b110`, the counter does not run, edges are not captured, no interrupt is raised and the status bit holds its value.
- R9: With `rd_addr`=0, `rd_data` returns the status word: overflow flag in bit 0, bits 15..1 zero. With `rd_addr`=1, it returns the zero-extended capture value. Reset clears the status word, the capture value and `cap_irq`.
- R10: A start pulse in a capture mode restarts the counter at 0 and discards any pending wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode code |
| start | input | 1 | Start pulse: arms the counter and restarts it at zero |
| cap_in | input | 1 | Asynchronous capture input |
| rd_addr | input | 1 | Read select: 0 status word, 1 capture value |
| rd_data | output | 16 | Selected read data |
| cap_irq | output | 1 | One-cycle pulse per capture |

## Verification
Intervals are chosen on both sides of the counter range. A short interval with no wrap shows the flag clears. Intervals several wraps long show the flag sets. The three intervals one clock below, at, and one clock above a full period show whether a wrap on the capture clock is credited to the closing interval.

A short interval after a long one shows that a stale 1 is cleared. Reading the status just after a wrap, before the next capture, shows that the update is deferred. Pulses in an idle mode and after a single-shot capture must produce nothing. A restart issued after a wrap shows that the pending wrap is discarded.

// File: rtl/cap_tmr_pkg.sv
`timescale 1ns/1ps
package cap_tmr_pkg;

    localparam int STAT_W = 16;

    localparam logic [2:0] MODE_CAP_CONT = 3'b010;
    localparam logic [2:0] MODE_CAP_ONE  = 3'b110;

    typedef enum logic {
        RD_STATUS  = 1'b0,
        RD_CAPTURE = 1'b1
    } rd_sel_e;

    typedef struct packed {
        logic fire;     // capture accepted this cycle
        logic wrapped;  // a wrap belongs to the interval being closed
    } cap_evt_t;

    function automatic logic mode_is_capture(input logic [2:0] m);
        return (m == MODE_CAP_CONT) || (m == MODE_CAP_ONE);
    endfunction

    function automatic logic mode_is_single(input logic [2:0] m);
        return m == MODE_CAP_ONE;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input logic flag);
        logic [STAT_W-1:0] w;
        w    = '0;
        w[0] = flag;
        return w;
    endfunction

endpackage

// File: rtl/cap_edge_sync.sv
`timescale 1ns/1ps
module cap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            last_q <= sh_q[STAGES-1];
        end
    end

    assign rise = sh_q[STAGES-1] & ~last_q;

    // R2: an accepted edge never lasts two cycles
    assert_single_rise_R2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/cap_counter.sv
`timescale 1ns/1ps
module cap_counter
    import cap_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode,
    input  logic             start,
    input  logic             edge_in,
    output cap_evt_t         evt,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             run_q, pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cap_mode, count_en, wrap_now, fire, restart;

    assign cap_mode = mode_is_capture(mode);
    assign count_en = run_q & cap_mode;
    assign wrap_now = count_en & (cnt_q == '1);
    assign fire     = edge_in & count_en;
    assign restart  = start & cap_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (fire) begin
                cnt_q  <= '0;
                pend_q <= 1'b0;
                if (mode_is_single(mode)) run_q <= 1'b0;
            end else if (count_en) begin
                cnt_q <= cnt_q + ONE;
                if (wrap_now) pend_q <= 1'b1;
            end
            if (restart) begin
                cnt_q  <= '0;
                pend_q <= 1'b0;
                run_q  <= 1'b1;
            end
        end
    end

    assign evt.fire    = fire;
    assign evt.wrapped = pend_q | wrap_now;
    assign count       = cnt_q;

    // R1: counter restarts at zero after a capture
    assert_restart_R1: assert property (@(posedge clk) disable iff (rst)
        fire |=> cnt_q == '0);
    // R1: steady increment while running
    assert_increment_R1: assert property (@(posedge clk) disable iff (rst)
        (count_en && !fire && !restart) |=> cnt_q == $past(cnt_q) + ONE);
    // R7: single-shot halts after capture
    assert_single_halt_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && mode_is_single(mode) && !restart) |=> !run_q);
    // R8: idle modes freeze the count
    assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode && !fire) |=> $stable(cnt_q));
    // R10: start discards a pending wrap
    assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!pend_q && cnt_q == '0));

endmodule

// File: rtl/cap_status.sv
`timescale 1ns/1ps
module cap_status
    import cap_tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cap_evt_t evt,
    output logic     ovf_flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (evt.fire) flag_q <= evt.wrapped;
    end

    assign ovf_flag = flag_q;

    // R3, R8: flag moves only at a capture
    assert_deferred_R3: assert property (@(posedge clk) disable iff (rst)
        !evt.fire |=> $stable(flag_q));
    // R4
    assert_set_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (evt.fire && evt.wrapped) |=> flag_q);
    // R5
    assert_clear_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.fire && !evt.wrapped) |=> !flag_q);

endmodule

// File: rtl/cap_interval_timer.sv
`timescale 1ns/1ps
module cap_interval_timer
    import cap_tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  mode,
    input  logic        start,
    input  logic        cap_in,
    input  logic        rd_addr,
    output logic [15:0] rd_data,
    output logic        cap_irq
);
    logic             rise;
    cap_evt_t         evt;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap_q;
    logic             irq_q;
    logic             ovf_flag;
    logic [STAT_W-1:0] cap_ext;

    cap_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk), .rst (rst), .din (cap_in), .rise (rise)
    );

    cap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk), .rst (rst), .mode (mode), .start (start),
        .edge_in (rise), .evt (evt), .count (count)
    );

    cap_status u_stat (
        .clk (clk), .rst (rst), .evt (evt), .ovf_flag (ovf_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= evt.fire;
            if (evt.fire) cap_q <= count;
        end
    end

    always_comb begin
        cap_ext              = '0;
        cap_ext[CNT_W-1:0]   = cap_q;
    end

    always_comb begin
        unique case (rd_sel_e'(rd_addr))
            RD_STATUS:  rd_data = pack_status(ovf_flag);
            RD_CAPTURE: rd_data = cap_ext;
            default:    rd_data = '0;
        endcase
    end

    assign cap_irq = irq_q;

    // R2: interrupt is a single-cycle pulse
    assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        cap_irq |=> !cap_irq);
    // R2: every capture raises the interrupt
    assert_irq_follows_R2: assert property (@(posedge clk) disable iff (rst)
        evt.fire |=> cap_irq);
    // R6: a wrap on the capture clock is credited to the closing interval
    assert_same_cycle_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.fire && count == '1 && mode_is_capture(mode)) |=> rd_addr || rd_data[0]);
    // R9: status word upper bits are always zero
    assert_status_upper_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_addr |-> rd_data[15:1] == '0);

endmodule

// File: tb/tb_cap_interval_timer.sv
`timescale 1ns/1ps
module tb_cap_interval_timer;
    localparam int W = 8;
    localparam int PERIOD = 1 << W;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'b010;
    logic        start = 1'b0;
    logic        cap_in = 1'b0;
    logic        rd_addr = 1'b0;
    logic [15:0] rd_data;
    logic        cap_irq;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int last_restart = 0;
    bit done = 0;

    typedef struct { int val; bit ovf; string req; } exp_t;
    exp_t sb[$];

    cap_interval_timer #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .mode(mode), .start(start), .cap_in(cap_in),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_irq(cap_irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    // monitor: pop expected item on each interrupt
    always @(negedge clk) begin
        if (!rst && cap_irq) begin
            logic [15:0] cv, sv;
            rd_addr = 1'b1; #0.5; cv = rd_data;
            rd_addr = 1'b0; #0.5; sv = rd_data;
            if (sb.size() == 0) begin
                check("R2/R7/R8 unexpected capture", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " capture value"}, int'(cv), e.val);
                check({e.req, " status flag"}, int'(sv[0]), int'(e.ovf));
                check("R9 status upper bits", int'(sv[15:1]), 0);
            end
        end
    end

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        last_restart = cyc + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // capture closing an interval of 'elapsed' clocks since last restart
    task automatic cap_after(input int elapsed, input string req);
        int x;
        exp_t e;
        x = last_restart + elapsed - 3;
        @(negedge clk);
        while (cyc < x) @(negedge clk);
        cap_in = 1'b1;
        e.val = (elapsed - 1) % PERIOD;
        e.ovf = (elapsed >= PERIOD);
        e.req = req;
        sb.push_back(e);
        last_restart = x + 3;
        while (cyc < x + 8) @(negedge clk);
        cap_in = 1'b0;
        while (cyc < x + 12) @(negedge clk);
    endtask

    task automatic pulse_ignored();
        @(negedge clk);
        cap_in = 1'b1;
        repeat (10) @(negedge clk);
        cap_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R9 reset state
        rd(1'b0, d); check("R9 reset status", int'(d), 0);
        rd(1'b1, d); check("R9 reset capture", int'(d), 0);
        check("R9 reset irq", int'(cap_irq), 0);

        do_start();
        cap_after(20, "R1 R5 short");
        // R3: wrap occurs but status untouched before capture
        while (cyc < last_restart + PERIOD + 10) @(negedge clk);
        rd(1'b0, d); check("R3 deferred after wrap", int'(d), 0);
        cap_after(PERIOD * 2 + 40, "R4 multi-wrap");
        cap_after(30, "R5 clear after set");
        cap_after(PERIOD - 1, "R6 below period");
        cap_after(PERIOD, "R6 at period");
        cap_after(PERIOD + 1, "R6 above period");
        cap_after(15, "R2 back-to-back");
        cap_after(PERIOD + 5, "R4 set again");

        // R8: idle mode
        @(negedge clk) mode = 3'b000;
        pulse_ignored();
        pulse_ignored();
        rd(1'b0, d); check("R8 status held", int'(d), 1);
        rd(1'b1, d); check("R8 capture held", int'(d), 4);
        @(negedge clk) mode = 3'b011;
        pulse_ignored();
        rd(1'b0, d); check("R8 status held mode 3", int'(d), 1);

        // R7: single-shot
        @(negedge clk) mode = 3'b110;
        do_start();
        cap_after(25, "R7 single capture");
        pulse_ignored();
        rd(1'b1, d); check("R7 halted capture value", int'(d), 24);
        rd(1'b0, d); check("R7 halted status", int'(d), 0);

        // R10: start discards pending wrap
        @(negedge clk) mode = 3'b010;
        do_start();
        while (cyc < last_restart + PERIOD + 20) @(negedge clk);
        do_start();
        cap_after(40, "R10 restart clears pending");

        repeat (10) @(negedge clk);
        check("R2 all expected captures seen", sb.size(), 0);
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                fails++;
                vectors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule